// File: doc/BRIEF.md
# Key-Sequenced Watchdog Arming Controller

This block guards a watchdog behind a memory-mapped control register. Software arms it by writing two fixed 16-bit keys in order, each with the enable bit set. The first key is accepted only while the surrounding timer is configured for watchdog mode. Once armed, the watchdog stays armed. It counts ticks from an external time base. Software keeps it alive by repeating the two-key service sequence before the tick budget runs out.

A wrong key written to the armed watchdog raises a system reset request at once. The request also rises when the tick budget runs out. The request stays latched until the block's own synchronous reset. Reads of the control register return a status word that shows the arming state, the enable flag and the reset request.

Top module: `wdog_unlock_ctrl`

## Requirements
- R1: The control register lives at byte address 0x28. Writes to any other address have no effect. A read at 0x28 returns the status word; a read elsewhere returns 0. Status word layout: bit 14 is the enable flag (1 in every state but inactive), bit 2 is the reset request, bits 1:0 are the state code (0 inactive, 1 pre-active, 2 active, 3 active with first service key taken), and all other bits read 0.
- R2: From inactive, a write whose key field (bits 31:16) is 0xA5C6, with bit 14 set and the mode input equal to 2, moves the block to pre-active.
- R3: In pre-active, a write of key 0xDA7E with bit 14 set moves the block to active. A write of 0xA5C6 with bit 14 set keeps it pre-active. Any other write to the register returns it to inactive.
- R4: In inactive, a write is ignored if its key is wrong, if bit 14 is clear, or if the mode input is not 2.
- R5: In either active state, a write whose key is neither 0xA5C6 nor 0xDA7E sets the reset request on the clock edge that takes the write.
- R6: When active, 0xA5C6 moves the block to state 3. When in state 3, 0xDA7E returns it to state 2 and restarts the tick count. A lone 0xDA7E in state 2 changes nothing, the count included. In the active states, bit 14 of the write is not examined.
- R7: In the active states, the reset request rises on the edge that samples the TIMEOUT_TICKS-th tick. Ticks are counted from arming or from the last completed service.
- R8: Once active, no write with a valid key, no change of the mode input and no tick returns the block to inactive or pre-active.
- R9: The reset request stays high until rst_n is asserted. Further writes or ticks do not clear it.
- R10: A synchronous active-low reset puts the block in inactive with the reset request low and the count cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data: key in bits 31:16, enable in bit 14 |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data (status word or 0) |
| mode_sel | input | 2 | Global timer mode; 2 selects watchdog mode |
| tick | input | 1 | Time-base tick for the timeout count |
| rst_req | output | 1 | Latched system reset request |

## Verification
The hardest case is telling a restarted count apart from one that was never restarted. Ticks alone cannot show this. The stimulus builds a partial count, then writes a lone second key in state 2, and shows that the request still fires on schedule. In another run, a full service splits the ticks, and the request must not fire where the unserviced count would have expired. It must fire exactly TIMEOUT_TICKS ticks after the service. Wrong-key resets are reached from state 3 as well as state 2. After a request, valid service writes follow, to show the request does not clear.

// File: rtl/wdog_pkg.sv
// Package: shared state encoding and key constants for the watchdog arming
// controller. Assumes a 32-bit control word with the key in the upper half.
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_PRE    = 2'd1,
        WD_ACTIVE = 2'd2,
        WD_KEYED  = 2'd3
    } wd_state_e;

    localparam logic [15:0] KEY_ARM     = 16'hA5C6;
    localparam logic [15:0] KEY_CONFIRM = 16'hDA7E;
    localparam int          EN_BIT      = 14;
    localparam logic [1:0]  WDOG_MODE   = 2'd2;
endpackage

// File: rtl/wdog_key_decode.sv
// Key decoder: classifies a write to the control register by its key field.
// Assumes a single-cycle write strobe; purely combinational.
module wdog_key_decode #(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h28
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              hit,
    output logic              key_arm,
    output logic              key_confirm,
    output logic              key_bad,
    output logic              en_bit
);
    import wdog_pkg::*;

    logic [15:0] key;
    logic        unused_bits;

    // Split the write word into key and enable fields.
    always_comb begin
        key         = wr_data[31:16];
        en_bit      = wr_data[EN_BIT];
        unused_bits = ^{wr_data[15], wr_data[13:0]};
    end

    // Classify the key of a write addressed to the register.
    always_comb begin
        hit         = wr_en && (wr_addr == REG_OFFSET);
        key_arm     = (key == KEY_ARM);
        key_confirm = (key == KEY_CONFIRM);
        key_bad     = !key_arm && !key_confirm;
    end
endmodule

// File: rtl/wdog_timeout_ctr.sv
// Timeout counter: counts ticks while run is high and flags expiry on the
// tick that completes TIMEOUT_TICKS. Cleared while idle or on restart.
module wdog_timeout_ctr #(
    parameter int TIMEOUT_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt;

    // Expiry fires when the final tick arrives and no restart is pending.
    always_comb begin
        expired = run && tick && !restart && (cnt == LAST);
    end

    // Tick counter, held at the last value once the budget is spent.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_arm_fsm.sv
// Arming state machine: walks inactive -> pre-active -> active on the key
// sequence, tracks the two-step service, and latches the reset request.
// Assumes decoded key flags from wdog_key_decode.
module wdog_arm_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic               key_arm,
    input  logic               key_confirm,
    input  logic               key_bad,
    input  logic               en_bit,
    input  logic [1:0]         mode_sel,
    input  logic               expired,
    output wdog_pkg::wd_state_e state,
    output logic               service,
    output logic               req
);
    import wdog_pkg::*;

    wd_state_e state_nx;
    logic      armed;

    // Next-state decode for the key sequence.
    always_comb begin
        state_nx = state;
        service  = 1'b0;
        armed    = (state == WD_ACTIVE) || (state == WD_KEYED);
        if (hit) begin
            unique case (state)
                WD_IDLE: begin
                    if (key_arm && en_bit && (mode_sel == WDOG_MODE))
                        state_nx = WD_PRE;
                end
                WD_PRE: begin
                    if (key_arm && en_bit)          state_nx = WD_PRE;
                    else if (key_confirm && en_bit) state_nx = WD_ACTIVE;
                    else                            state_nx = WD_IDLE;
                end
                WD_ACTIVE: begin
                    if (key_arm) state_nx = WD_KEYED;
                end
                WD_KEYED: begin
                    if (key_confirm) begin
                        state_nx = WD_ACTIVE;
                        service  = 1'b1;
                    end
                end
                default: state_nx = WD_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_nx;
    end

    // Sticky reset request from a wrong key or an expired count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if ((armed && hit && key_bad) || expired)
            req <= 1'b1;
    end
endmodule

// File: rtl/wdog_unlock_ctrl.sv
// Top: key-sequenced watchdog arming controller. Ties the key decoder, the
// arming state machine and the timeout counter together and builds the
// status word seen on reads of the control register.
module wdog_unlock_ctrl #(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET    = 8'h28,
    parameter int                TIMEOUT_TICKS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [1:0]        mode_sel,
    input  logic              tick,
    output logic              rst_req
);
    import wdog_pkg::*;

    logic      hit, key_arm, key_confirm, key_bad, en_bit;
    logic      service, expired, run;
    wd_state_e fsm_state;

    wdog_key_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hit(hit), .key_arm(key_arm), .key_confirm(key_confirm),
        .key_bad(key_bad), .en_bit(en_bit)
    );

    wdog_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .key_arm(key_arm),
        .key_confirm(key_confirm), .key_bad(key_bad), .en_bit(en_bit),
        .mode_sel(mode_sel), .expired(expired), .state(fsm_state),
        .service(service), .req(rst_req)
    );

    // Counter runs in both active states.
    always_comb begin
        run = (fsm_state == WD_ACTIVE) || (fsm_state == WD_KEYED);
    end

    wdog_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(service),
        .tick(tick), .expired(expired)
    );

    // Status word read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_OFFSET) begin
            rd_data[EN_BIT] = (fsm_state != WD_IDLE);
            rd_data[2]      = rst_req;
            rd_data[1:0]    = fsm_state;
        end
    end
endmodule

// File: rtl/wdog_unlock_ctrl_chk.sv
// Checker: temporal properties of the arming controller, bound to the top.
module wdog_unlock_ctrl_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [1:0]        mode_sel,
    input logic [1:0]        state,
    input logic              rst_req
);
    logic reg_wr, good_key, arm_ok;

    // Port-level view of the write, independent of the decoder.
    always_comb begin
        reg_wr   = wr_en && (wr_addr == REG_OFFSET);
        good_key = (wr_data[31:16] == 16'hA5C6) || (wr_data[31:16] == 16'hDA7E);
        arm_ok   = reg_wr && (wr_data[31:16] == 16'hA5C6) && wr_data[14]
                   && (mode_sel == 2'd2);
    end

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);                                          // R9
    AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        state[1] |=> state[1]);                                        // R8
    AST_BAD_KEY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state[1] && reg_wr && !good_key) |=> rst_req);                // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && !arm_ok) |=> (state == 2'd0));               // R4
    AST_IDLE_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && arm_ok) |=> (state == 2'd1));                // R2
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0) |-> !rst_req);                                 // R10
endmodule

bind wdog_unlock_ctrl wdog_unlock_ctrl_chk #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .state(fsm_state),
    .rst_req(rst_req)
);

// File: tb/wdog_unlock_ctrl_tb.sv
module wdog_unlock_ctrl_tb;
    localparam int TO = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h28;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h28;
    logic [31:0] rd_data;
    logic [1:0]  mode_sel = 2'd2;
    logic        tick = 1'b0;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdog_unlock_ctrl #(.ADDR_W(8), .REG_OFFSET(8'h28), .TIMEOUT_TICKS(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mode_sel(mode_sel), .tick(tick), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [1:0]  mode;
        logic        tk;
        logic [31:0] exp;
    } vec_t;

    // Status codes: 0 idle, 4001 pre, 4002 active, 4003 keyed, +4 request.
    localparam vec_t VECS [18] = '{
        '{"R4", 1'b1, 8'h28, 32'h12344000, 2'd2, 1'b0, 32'h0},
        '{"R4", 1'b1, 8'h28, 32'hA5C60000, 2'd2, 1'b0, 32'h0},
        '{"R1", 1'b1, 8'h24, 32'hA5C64000, 2'd2, 1'b0, 32'h0},
        '{"R4", 1'b1, 8'h28, 32'hA5C64000, 2'd0, 1'b0, 32'h0},
        '{"R2", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001},
        '{"R3", 1'b1, 8'h28, 32'h12344000, 2'd2, 1'b0, 32'h0},
        '{"R2", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001},
        '{"R3", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001},
        '{"R3", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4002},
        '{"R6", 1'b1, 8'h28, 32'hA5C60000, 2'd2, 1'b0, 32'h4003},
        '{"R6", 1'b1, 8'h28, 32'hDA7E0000, 2'd2, 1'b0, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4002},
        '{"R6", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002},
        '{"R7", 1'b0, 8'h28, 32'h0,        2'd2, 1'b1, 32'h4006}
    };

    task automatic check(input string tag, input logic [31:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    // Called at a negedge: drive, cross one posedge, release, check.
    task automatic step(input string tag, input logic wr, input logic [7:0] addr,
                        input logic [31:0] data, input logic [1:0] mode,
                        input logic tk, input logic [31:0] exp);
        wr_en = wr; wr_addr = addr; wr_data = data; mode_sel = mode; tick = tk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(tag, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mode_sel = 2'd2;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_fail++; n_chk++;
                $display("FAIL watchdog: run hung, expected completion");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        @(negedge clk);
        do_reset();
        check("R10", 32'h0);

        for (int i = 0; i < 18; i++) begin
            step($sformatf("%s", VECS[i].tag), VECS[i].wr, VECS[i].addr,
                 VECS[i].data, VECS[i].mode, VECS[i].tk, VECS[i].exp);
        end

        // R9: request survives valid writes and ticks, cleared only by reset.
        step("R9", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b1, 32'h4007);
        do_reset();
        check("R9", 32'h0);
        rd_addr = 8'h20;
        check("R1", 32'h0);
        rd_addr = 8'h28;

        // R8: no way back once active.
        step("R2", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001);
        step("R3", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002);
        step("R8", 1'b1, 8'h28, 32'hDA7E0000, 2'd0, 1'b0, 32'h4002);
        step("R8", 1'b0, 8'h28, 32'h0,        2'd1, 1'b1, 32'h4002);
        step("R6", 1'b1, 8'h28, 32'hA5C60000, 2'd0, 1'b0, 32'h4003);
        // R5: wrong key from state 3.
        step("R5", 1'b1, 8'h28, 32'h00004000, 2'd2, 1'b0, 32'h4007);
        step("R9", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4006);

        // R5 from state 2, R7 boundary after a service.
        do_reset();
        step("R2", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001);
        step("R3", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002);
        step("R7", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4002);
        step("R7", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4002);
        step("R6", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4003);
        step("R6", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002);
        step("R7", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4002);
        step("R7", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4002);
        step("R6", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4002);
        step("R7", 1'b0, 8'h28, 32'h0, 2'd2, 1'b1, 32'h4006);

        do_reset();
        step("R2", 1'b1, 8'h28, 32'hA5C64000, 2'd2, 1'b0, 32'h4001);
        step("R3", 1'b1, 8'h28, 32'hDA7E4000, 2'd2, 1'b0, 32'h4002);
        step("R5", 1'b1, 8'h28, 32'h00004000, 2'd2, 1'b0, 32'h4006);
        step("R1", 1'b1, 8'h2C, 32'h00004000, 2'd2, 1'b0, 32'h4006);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule